// File: doc/BRIEF.md
# Suspend Modulation Clock Throttle

The block throttles a processor by toggling an active-low suspend request. While modulation is enabled, the request alternates between an asserted phase and a released phase. The asserted phase is the programmed ON count of timebase ticks long and idles the CPU. The released phase is the programmed OFF count long and lets the CPU run. The effective speed is therefore full speed × OFF / (OFF + ON). One tick of the timebase input is nominally 32 µs. A millisecond tick is made by dividing that same input by `TICKS_PER_MS`.

A byte-wide register port carries six registers:

| Address | Contents |
|---|---|
| 0x94 | OFF count |
| 0x95 | ON count |
| 0x96 | Configuration; bit 0 enables modulation |
| 0x80 | Power-management enable |
| 0x8C | Interrupt hold-off, in milliseconds |
| 0x8D | Video hold-off, in milliseconds |

In the power-management enable byte, bit 3 arms the interrupt speedup and bit 4 arms the video speedup. An armed activity pulse reloads its hold-off counter. While either hold-off counter is nonzero, the suspend output is forced released, and the phase counter keeps running underneath.

The register port is a plain write strobe with a combinational read mux. It applies no back-pressure: a write lands on the clock edge where `wr_en` is high, and a read returns the addressed byte in the same cycle.

Top module: `suspmod_throttle`

## Requirements
- R1: After reset, `susp_n_o` is 1 and every mapped register reads 0x00.
- R2: The bytes at 0x80, 0x8C, 0x8D, 0x94, 0x95 and 0x96 read back the last value written to them. Any other address reads 0x00, and a write to it changes no register.
- R3: With configuration bit 0 set, the output is held low for ON ticks and then high for OFF ticks, and this repeats. The first ON phase starts on the first tick after the enable bit is seen.
- R4: While configuration bit 0 is clear, `susp_n_o` is 1 and the phase sequence restarts from its initial state.
- R5: A phase whose count is zero is skipped. When both counts are zero, the output stays 1.
- R6: A new ON or OFF count takes effect at the next phase boundary. A write in the same cycle as a boundary tick is seen only at the following boundary.
- R7: A millisecond tick occurs on every `TICKS_PER_MS`-th tick pulse, counted from reset.
- R8: With enable bit 3 set, an interrupt pulse loads the interrupt hold-off counter from 0x8C. Each millisecond tick then decrements it by one until it reaches zero, and while it is nonzero `susp_n_o` is 1.
- R9: With enable bit 4 set, a video pulse loads the video hold-off counter from 0x8D. That counter then behaves exactly as in R8.
- R10: When an activity pulse and a millisecond tick fall in the same cycle, the reload wins over the decrement.
- R11: While a speedup enable bit is clear, its activity pulses are ignored and its hold-off counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse (one phase unit) |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_evt_i | input | 1 | Interrupt activity pulse |
| vid_evt_i | input | 1 | Video activity pulse |
| susp_n_o | output | 1 | Active-low suspend request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is an activity pulse and a millisecond tick. The bench provokes it by repeating interrupt and video pulses across several millisecond boundaries, so that some pulses meet a tick. A behavioural model then expects the hold-off counter to hold the reload value rather than that value minus one.

The second pair is a count write and a phase boundary tick. The bench watches its model for the last tick of a phase and issues the write in that cycle. It then compares the output every clock to show that the old length governs the next phase.

// File: rtl/suspmod_pkg.sv
package suspmod_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t A_PMCTL    = 8'h80;
  localparam byte_t A_IRQ_HOLD = 8'h8C;
  localparam byte_t A_VID_HOLD = 8'h8D;
  localparam byte_t A_OFF_LEN  = 8'h94;
  localparam byte_t A_ON_LEN   = 8'h95;
  localparam byte_t A_CFG      = 8'h96;

  localparam int unsigned B_MOD_EN  = 0;
  localparam int unsigned B_IRQ_SPD = 3;
  localparam int unsigned B_VID_SPD = 4;

  localparam int unsigned N_SRC   = 2;
  localparam int unsigned SRC_IRQ = 0;
  localparam int unsigned SRC_VID = 1;
endpackage

// File: rtl/suspmod_regs.sv
module suspmod_regs
  import suspmod_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  byte_t                    addr,
  input  byte_t                    wdata,
  output byte_t                    rdata,
  output byte_t                    off_len,
  output byte_t                    on_len,
  output logic                     mod_en,
  output logic [N_SRC-1:0]         spd_en,
  output logic [N_SRC-1:0][BYTE_W-1:0] hold_len
);
  byte_t pm_q, irqh_q, vidh_q, off_q, on_q, cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q   <= '0;
      irqh_q <= '0;
      vidh_q <= '0;
      off_q  <= '0;
      on_q   <= '0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PMCTL:    pm_q   <= wdata;
        A_IRQ_HOLD: irqh_q <= wdata;
        A_VID_HOLD: vidh_q <= wdata;
        A_OFF_LEN:  off_q  <= wdata;
        A_ON_LEN:   on_q   <= wdata;
        A_CFG:      cfg_q  <= wdata;
        default: ;
      endcase
    end
  end

  logic mapped;
  always_comb begin
    mapped = 1'b1;
    rdata  = '0;
    case (addr)
      A_PMCTL:    rdata = pm_q;
      A_IRQ_HOLD: rdata = irqh_q;
      A_VID_HOLD: rdata = vidh_q;
      A_OFF_LEN:  rdata = off_q;
      A_ON_LEN:   rdata = on_q;
      A_CFG:      rdata = cfg_q;
      default:    mapped = 1'b0;
    endcase
  end

  assign off_len           = off_q;
  assign on_len            = on_q;
  assign mod_en            = cfg_q[B_MOD_EN];
  assign spd_en[SRC_IRQ]   = pm_q[B_IRQ_SPD];
  assign spd_en[SRC_VID]   = pm_q[B_VID_SPD];
  assign hold_len[SRC_IRQ] = irqh_q;
  assign hold_len[SRC_VID] = vidh_q;

  p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rdata == '0);
  p_off_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OFF_LEN) |=> off_len == $past(wdata));
  p_unmapped_write_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> $stable(off_len) && $stable(on_len) && $stable(mod_en));
endmodule

// File: rtl/suspmod_msdiv.sv
module suspmod_msdiv #(
  parameter int unsigned TICKS_PER_MS = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ms_tick
);
  localparam int unsigned DW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICKS_PER_MS - 1);

  logic [DW-1:0] cnt_q;
  logic          wrap;

  assign wrap    = (cnt_q == LAST);
  assign ms_tick = tick & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  p_div_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_div_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/suspmod_phase.sv
module suspmod_phase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_len,
  input  logic [CNT_W-1:0] off_len,
  output logic             active
);
  logic             on_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] len_next, len_same;
  logic             boundary;

  assign len_next = on_q ? off_len : on_len;
  assign len_same = on_q ? on_len  : off_len;
  assign boundary = (rem_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else if (!en) begin
      on_q  <= 1'b0;
      rem_q <= '0;
    end else if (tick) begin
      if (!boundary) begin
        rem_q <= rem_q - 1'b1;
      end else if (len_next != '0) begin
        on_q  <= ~on_q;
        rem_q <= len_next;
      end else if (len_same != '0) begin
        rem_q <= len_same;
      end else begin
        on_q  <= 1'b0;
        rem_q <= '0;
      end
    end
  end

  assign active = on_q;

  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active && rem_q == '0);
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !boundary) |=> (rem_q == $past(rem_q) - 1'b1) && $stable(on_q));
  p_both_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && boundary && on_len == '0 && off_len == '0) |=> !active);
  p_on_has_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> rem_q != '0);
endmodule

// File: rtl/suspmod_holdoff.sv
module suspmod_holdoff #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_en,
  input  logic             evt,
  input  logic             ms_tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (!spd_en)                 cnt_q <= '0;
    else if (evt)                     cnt_q <= load_val;
    else if (ms_tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_reload_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_en && evt) |=> cnt_q == $past(load_val));
  p_disarm_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !spd_en |=> !busy);
  p_hold_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_en && !evt && !ms_tick) |=> $stable(cnt_q));
endmodule

// File: rtl/suspmod_throttle.sv
module suspmod_throttle
  import suspmod_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_evt_i,
  input  logic       vid_evt_i,
  output logic       susp_n_o
);
  byte_t                        off_len, on_len;
  logic                         mod_en;
  logic [N_SRC-1:0]             spd_en;
  logic [N_SRC-1:0][BYTE_W-1:0] hold_len;
  logic [N_SRC-1:0]             evt_vec, busy_vec;
  logic                         ms_tick, phase_on, hold_any;

  suspmod_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .off_len(off_len), .on_len(on_len), .mod_en(mod_en),
    .spd_en(spd_en), .hold_len(hold_len)
  );

  suspmod_msdiv #(.TICKS_PER_MS(TICKS_PER_MS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .ms_tick(ms_tick)
  );

  suspmod_phase #(.CNT_W(BYTE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .tick(tick_i),
    .on_len(on_len), .off_len(off_len), .active(phase_on)
  );

  assign evt_vec[SRC_IRQ] = irq_evt_i;
  assign evt_vec[SRC_VID] = vid_evt_i;

  for (genvar s = 0; s < N_SRC; s++) begin : g_hold
    suspmod_holdoff #(.CNT_W(BYTE_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .spd_en(spd_en[s]), .evt(evt_vec[s]),
      .ms_tick(ms_tick), .load_val(hold_len[s]), .busy(busy_vec[s])
    );
  end

  assign hold_any = |busy_vec;
  assign susp_n_o = ~(mod_en & phase_on & ~hold_any);

  p_hold_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_any |-> susp_n_o);
  p_disabled_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> susp_n_o);
endmodule

// File: tb/tb_suspmod_throttle.sv
module tb_suspmod_throttle;
  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;
  localparam int TICK_GAP   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_evt_i = 1'b0;
  logic       vid_evt_i = 1'b0;
  logic       susp_n_o;

  suspmod_throttle #(.TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_evt_i(irq_evt_i), .vid_evt_i(vid_evt_i), .susp_n_o(susp_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_pm, m_ih, m_vh, m_off, m_on, m_cfg;
  int m_ph, m_rem, m_div, m_h0, m_h1;

  function automatic int m_read(input int a);
    case (a)
      8'h80: return m_pm;
      8'h8C: return m_ih;
      8'h8D: return m_vh;
      8'h94: return m_off;
      8'h95: return m_on;
      8'h96: return m_cfg;
      default: return 0;
    endcase
  endfunction

  function automatic int m_susp();
    return ((m_cfg & 1) != 0 && m_ph == 1 && m_h0 == 0 && m_h1 == 0) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm = 0; m_ih = 0; m_vh = 0; m_off = 0; m_on = 0; m_cfg = 0;
      m_ph = 0; m_rem = 0; m_div = 0; m_h0 = 0; m_h1 = 0;
    end else begin
      int ms, ln, ls;
      ms = 0;
      if (tick_i) begin
        if (m_div == TPM - 1) begin m_div = 0; ms = 1; end
        else m_div = m_div + 1;
      end
      if ((m_cfg & 1) == 0) begin
        m_ph = 0; m_rem = 0;
      end else if (tick_i) begin
        if (m_rem > 1) m_rem = m_rem - 1;
        else begin
          ln = m_ph ? m_off : m_on;
          ls = m_ph ? m_on : m_off;
          if (ln != 0)      begin m_ph = 1 - m_ph; m_rem = ln; end
          else if (ls != 0) m_rem = ls;
          else              begin m_ph = 0; m_rem = 0; end
        end
      end
      if ((m_pm & 8) == 0) m_h0 = 0;
      else if (irq_evt_i)  m_h0 = m_ih;
      else if (ms && m_h0 != 0) m_h0 = m_h0 - 1;
      if ((m_pm & 16) == 0) m_h1 = 0;
      else if (vid_evt_i)   m_h1 = m_vh;
      else if (ms && m_h1 != 0) m_h1 = m_h1 - 1;
      if (wr_en) begin
        case (reg_addr)
          8'h80: m_pm  = reg_wdata;
          8'h8C: m_ih  = reg_wdata;
          8'h8D: m_vh  = reg_wdata;
          8'h94: m_off = reg_wdata;
          8'h95: m_on  = reg_wdata;
          8'h96: m_cfg = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, int'(susp_n_o), m_susp());
      chk(cur_req, int'(reg_rdata), m_read(int'(reg_addr)));
    end
  end

  // Timebase pulse generator
  int cyc = 0;
  always @(negedge clk) begin
    #1;
    cyc++;
    tick_i = (cyc % TICK_GAP == 0);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #2;
    wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    @(negedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_irq();
    @(negedge clk); #2; irq_evt_i = 1'b1;
    @(negedge clk); #2; irq_evt_i = 1'b0;
  endtask

  task automatic pulse_vid();
    @(negedge clk); #2; vid_evt_i = 1'b1;
    @(negedge clk); #2; vid_evt_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    chk("R1", int'(susp_n_o), 1);
    rd_chk("R1", 8'h80, 0);
    rd_chk("R1", 8'h8C, 0);
    rd_chk("R1", 8'h8D, 0);
    rd_chk("R1", 8'h94, 0);
    rd_chk("R1", 8'h95, 0);
    rd_chk("R1", 8'h96, 0);

    // R2: readback and unmapped addresses
    cur_req = "R2";
    wr(8'h80, 8'h07); wr(8'h8C, 8'h11); wr(8'h8D, 8'h22);
    wr(8'h94, 8'h33); wr(8'h95, 8'h44); wr(8'h96, 8'hFE);
    rd_chk("R2", 8'h80, 8'h07);
    rd_chk("R2", 8'h8C, 8'h11);
    rd_chk("R2", 8'h8D, 8'h22);
    rd_chk("R2", 8'h94, 8'h33);
    rd_chk("R2", 8'h95, 8'h44);
    rd_chk("R2", 8'h96, 8'hFE);
    wr(8'h97, 8'hA5); wr(8'h00, 8'h5A);
    rd_chk("R2", 8'h97, 0);
    rd_chk("R2", 8'h96, 8'hFE);
    rd_chk("R2", 8'h94, 8'h33);
    wr(8'h80, 8'h00);

    // R3: basic modulation, two settings
    cur_req = "R3";
    wr(8'h95, 8'd3); wr(8'h94, 8'd2); wr(8'h96, 8'h01);
    run(80);
    wr(8'h95, 8'd1); wr(8'h94, 8'd4);
    run(80);

    // R6: count write on the boundary tick
    cur_req = "R6";
    for (int k = 0; k < 3; k++) begin
      int guard = 0;
      forever begin
        @(negedge clk); #2;
        guard++;
        if ((m_rem == 1 && tick_i) || guard > 200) break;
      end
      wr_en = 1'b1; reg_addr = (k % 2) ? 8'h94 : 8'h95; reg_wdata = 8'(k + 2);
      @(negedge clk); #2; wr_en = 1'b0;
      run(40);
    end

    // R5: zero-length phases
    cur_req = "R5";
    wr(8'h95, 8'd0); wr(8'h94, 8'd2);
    run(40);
    chk("R5", int'(susp_n_o), 1);
    wr(8'h94, 8'd0);
    run(40);
    chk("R5", int'(susp_n_o), 1);
    wr(8'h95, 8'd2);
    run(40);
    chk("R5", int'(susp_n_o), 0);

    // R4: disable
    cur_req = "R4";
    wr(8'h96, 8'h00);
    run(30);
    chk("R4", int'(susp_n_o), 1);
    wr(8'h95, 8'd5); wr(8'h94, 8'd1); wr(8'h96, 8'h01);
    run(30);

    // R8: interrupt hold-off
    cur_req = "R8";
    wr(8'h8C, 8'd2); wr(8'h80, 8'h08);
    pulse_irq();
    chk("R8", int'(susp_n_o), 1);
    run(120);

    // R7: millisecond divider observed through hold-off expiry
    cur_req = "R7";
    wr(8'h8C, 8'd1);
    pulse_irq();
    run(60);

    // R10: repeated pulses meeting millisecond ticks
    cur_req = "R10";
    wr(8'h8C, 8'd2); wr(8'h8D, 8'd1); wr(8'h80, 8'h18);
    for (int k = 0; k < 20; k++) begin
      pulse_irq();
      pulse_vid();
    end
    run(60);

    // R9: video hold-off alone
    cur_req = "R9";
    wr(8'h80, 8'h10); wr(8'h8D, 8'd3);
    pulse_vid();
    chk("R9", int'(susp_n_o), 1);
    run(150);

    // R11: disarm clears and pulses ignored
    cur_req = "R11";
    pulse_vid();
    run(3);
    wr(8'h80, 8'h00);
    run(5);
    for (int k = 0; k < 10; k++) begin
      pulse_irq();
      pulse_vid();
    end
    run(60);

    finish_run();
  end
endmodule